// File: doc/BRIEF.md
# Reversible-Gate Static Memory Bit Cell

This block stores data in bit cells whose selection and copy logic is built only from two reversible primitives. One is a three-line controlled swap: the control passes through unchanged, and the other two lines are exchanged when the control is 1. The other is a two-line controlled inversion. In each cell, a controlled swap steered by the word line decides whether the storage register reloads its own value or takes the data input. A controlled inversion produces a read-select line from the word line and the write enable. A further controlled swap qualifies that select with the read flag. Every gate output that nothing else uses leaves the block on a garbage bus, so the cost of each cell can be seen.

The parameter `BITS` sets how many cells sit side by side in one row. The word line enters the first cell and passes through the control line of each cell's first gate to the next cell. The last copy leaves the row as `wl_out`, so the next group of cells in the same row can be enabled from it. The stored bits and the data-out register update on the rising clock edge, and a synchronous reset clears both.

Top module: `revsram_cell`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every stored bit and every `dout` bit to 0, even if 1s were stored before.
- R2: While `wl_in` is 0, the stored bits keep their values at every edge, whatever `wr_flag`, `din` and `rd_flag` are.
- R3: With `wl_in`=1 and `wr_flag`=1 at a rising edge, each stored bit takes the matching `din` bit. The bits of a row are independent.
- R4: With `wl_in`=1, `wr_flag`=0 and `rd_flag`=1 at a rising edge, `dout` shows the stored bits after that edge.
- R5: With `wl_in`=1 and both flags at 1, the write takes place and `dout` keeps its previous value.
- R6: In any cycle that is not a read as defined in R4, `dout` keeps its value across the edge.
- R7: `wl_out` equals `wl_in` at all times, after passing through every cell of the row.
- R8: Each bit of `wr_line` equals `wl_in` AND `wr_flag`. Each bit of `rd_line` equals `wl_in` AND NOT `wr_flag` AND `rd_flag`. Both are combinational.
- R9: Each cell i drives four garbage lines, `garbage[4i+3:4i]`. Bit 0 is (NOT `wl_in`) AND `wr_flag`. Bit 1 is the stored bit when `wr_line` is 1, and `din[i]` otherwise. Bit 2 is `wl_in` AND NOT `wr_flag`. Bit 3 is 0 when bit 2 is 1, and `rd_flag` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wl_in | input | 1 | Word line from the row decoder or the previous cell group |
| wr_flag | input | 1 | Write request |
| rd_flag | input | 1 | Read request |
| din | input | BITS | Data to store |
| wl_out | output | 1 | Word line passed on to the next cell group |
| wr_line | output | BITS | Active write line of each cell |
| rd_line | output | BITS | Active read line of each cell |
| dout | output | BITS | Registered read data |
| garbage | output | 4*BITS | Unused reversible-gate outputs, four per cell |

## Verification
The stored bits cannot be seen directly. The only way to observe them is a later read through `dout`, so each hold case (R2, the R5 write under a simultaneous read, the R6 non-read cycles) is followed by a read whose value shows whether the bits were disturbed. The hardest case to reach is a reset that clears bits already set to 1. The stimulus first writes all ones and reads them back, then asserts reset and reads again. The bench also walks every combination of the three control inputs against two stored patterns to cover the garbage lines.

// File: rtl/revsram_pkg.sv
package revsram_pkg;

    // Number of unused gate outputs each cell exports.
    localparam int unsigned GARB_PER_CELL = 4;

    // Three-line controlled swap: control passes, lines a/b swap when control is 1.
    typedef struct packed {
        logic ctl;
        logic p;
        logic q;
    } swap3_t;

    // Two-line controlled inversion.
    typedef struct packed {
        logic ctl;
        logic x;
    } cnot2_t;

    // Garbage lines of one cell, in bus order (bit 3 down to bit 0).
    typedef struct packed {
        logic rd_rest;
        logic rsel_pass;
        logic acc_rest;
        logic en_rest;
    } cell_garb_t;

    function automatic swap3_t swap3(input logic c, input logic a, input logic b);
        swap3_t r;
        r.ctl = c;
        r.p   = c ? b : a;
        r.q   = c ? a : b;
        return r;
    endfunction

    function automatic cnot2_t cnot2(input logic a, input logic b);
        cnot2_t r;
        r.ctl = a;
        r.x   = a ^ b;
        return r;
    endfunction

endpackage

// File: rtl/rev_swap_gate.sv
module rev_swap_gate
    import revsram_pkg::*;
(
    input  logic c_i,
    input  logic a_i,
    input  logic b_i,
    output logic c_o,
    output logic p_o,
    output logic q_o
);
    swap3_t res;

    always_comb begin
        res = swap3(c_i, a_i, b_i);
    end

    assign c_o = res.ctl;
    assign p_o = res.p;
    assign q_o = res.q;
endmodule

// File: rtl/rev_cnot_gate.sv
module rev_cnot_gate
    import revsram_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    output logic a_o,
    output logic x_o
);
    cnot2_t res;

    always_comb begin
        res = cnot2(a_i, b_i);
    end

    assign a_o = res.ctl;
    assign x_o = res.x;
endmodule

// File: rtl/revsram_slice.sv
module revsram_slice
    import revsram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wl_i,
    input  logic       wr_i,
    input  logic       rd_i,
    input  logic       d_i,
    output logic       wl_o,
    output logic       wr_line_o,
    output logic       rd_line_o,
    output logic       dout_o,
    output cell_garb_t garb_o
);
    logic bit_q;
    logic dout_q;
    logic wen;
    logic wen_b;
    logic rsel;
    logic sel_d;
    logic rd_go;
    logic g_en;
    logic g_acc;
    logic g_rsel;
    logic g_rd;

    // Enable gate: passes the word line on, derives write enable.
    rev_swap_gate u_en (
        .c_i (wl_i),
        .a_i (1'b0),
        .b_i (wr_i),
        .c_o (wl_o),
        .p_o (wen),
        .q_o (g_en)
    );

    // Controlled inversion: wl XOR (wl AND wr) gives the read-select line.
    rev_cnot_gate u_sel (
        .a_i (wen),
        .b_i (wl_o),
        .a_o (wen_b),
        .x_o (rsel)
    );

    // Access gate: hold the stored bit, or take new data.
    rev_swap_gate u_acc (
        .c_i (wen_b),
        .a_i (bit_q),
        .b_i (d_i),
        .c_o (wr_line_o),
        .p_o (sel_d),
        .q_o (g_acc)
    );

    // Read qualifier.
    rev_swap_gate u_rd (
        .c_i (rsel),
        .a_i (1'b0),
        .b_i (rd_i),
        .c_o (g_rsel),
        .p_o (rd_go),
        .q_o (g_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            bit_q <= sel_d;
            if (rd_go) begin
                dout_q <= bit_q;
            end
        end
    end

    assign rd_line_o        = rd_go;
    assign dout_o           = dout_q;
    assign garb_o.en_rest   = g_en;
    assign garb_o.acc_rest  = g_acc;
    assign garb_o.rsel_pass = g_rsel;
    assign garb_o.rd_rest   = g_rd;
endmodule

// File: rtl/revsram_cell.sv
module revsram_cell
    import revsram_pkg::*;
#(
    parameter int unsigned BITS = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wl_in,
    input  logic                              wr_flag,
    input  logic                              rd_flag,
    input  logic [BITS-1:0]                   din,
    output logic                              wl_out,
    output logic [BITS-1:0]                   wr_line,
    output logic [BITS-1:0]                   rd_line,
    output logic [BITS-1:0]                   dout,
    output logic [BITS*GARB_PER_CELL-1:0]     garbage
);
    localparam int unsigned GARB_W = BITS * GARB_PER_CELL;

    logic [BITS:0] wl_chain;

    assign wl_chain[0] = wl_in;

    for (genvar i = 0; i < BITS; i++) begin : g_cell
        cell_garb_t garb_i;

        revsram_slice u_slice (
            .clk       (clk),
            .rst       (rst),
            .wl_i      (wl_chain[i]),
            .wr_i      (wr_flag),
            .rd_i      (rd_flag),
            .d_i       (din[i]),
            .wl_o      (wl_chain[i+1]),
            .wr_line_o (wr_line[i]),
            .rd_line_o (rd_line[i]),
            .dout_o    (dout[i]),
            .garb_o    (garb_i)
        );

        assign garbage[i*GARB_PER_CELL +: GARB_PER_CELL] = garb_i;
    end

    assign wl_out = wl_chain[BITS];

    if (GARB_W == 0) begin : g_bad
        initial $error("BITS must be at least 1");
    end
endmodule

// File: rtl/revsram_cell_chk.sv
module revsram_cell_chk #(
    parameter int unsigned BITS = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wl_in,
    input logic                  wr_flag,
    input logic                  rd_flag,
    input logic [BITS-1:0]       din,
    input logic                  wl_out,
    input logic [BITS-1:0]       wr_line,
    input logic [BITS-1:0]       rd_line,
    input logic [BITS-1:0]       dout
);
    // R1: reset clears data-out
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (dout == '0));

    // R7: word line reaches the end of the row unchanged
    p_wl_pass_r7: assert property (@(posedge clk) disable iff (rst) wl_out == wl_in);

    // R8: active write and read lines
    p_wr_line_r8: assert property (@(posedge clk) disable iff (rst)
        wr_line == {BITS{wl_in & wr_flag}});
    p_rd_line_r8: assert property (@(posedge clk) disable iff (rst)
        rd_line == {BITS{wl_in & ~wr_flag & rd_flag}});

    // R6: no read, no change on data-out
    p_dout_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(wl_in && !wr_flag && rd_flag) |=> $stable(dout));

    // R5: write with read flag set leaves data-out alone
    p_wr_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (wl_in && wr_flag && rd_flag) |=> $stable(dout));

    // R3: a write followed directly by a read returns the written data
    p_wr_rd_r3: assert property (@(posedge clk) disable iff (rst)
        (wl_in && wr_flag) ##1 (wl_in && !wr_flag && rd_flag) |=> (dout == $past(din, 2)));
endmodule

bind revsram_cell revsram_cell_chk #(.BITS(BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wl_in   (wl_in),
    .wr_flag (wr_flag),
    .rd_flag (rd_flag),
    .din     (din),
    .wl_out  (wl_out),
    .wr_line (wr_line),
    .rd_line (rd_line),
    .dout    (dout)
);

// File: tb/revsram_cell_tb_top.sv
module revsram_cell_tb_top;
    localparam int unsigned BITS = 2;
    localparam int unsigned GW   = BITS * 4;

    typedef struct {
        logic [BITS-1:0] dout;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b0;
    logic            wl_in = 1'b0;
    logic            wr_flag = 1'b0;
    logic            rd_flag = 1'b0;
    logic [BITS-1:0] din = '0;
    logic            wl_out;
    logic [BITS-1:0] wr_line;
    logic [BITS-1:0] rd_line;
    logic [BITS-1:0] dout;
    logic [GW-1:0]   garbage;

    int checks = 0;
    int errors = 0;

    exp_t            sb_q[$];
    logic [BITS-1:0] model_q = '0;
    logic [BITS-1:0] model_dout = '0;

    always #10 clk = ~clk;

    revsram_cell #(.BITS(BITS)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .wl_in   (wl_in),
        .wr_flag (wr_flag),
        .rd_flag (rd_flag),
        .din     (din),
        .wl_out  (wl_out),
        .wr_line (wr_line),
        .rd_line (rd_line),
        .dout    (dout),
        .garbage (garbage)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, combinational checks, push expected data-out.
    task automatic op(input logic w, input logic wr, input logic rd,
                      input logic [BITS-1:0] d, input string tag);
        exp_t            e;
        logic [GW-1:0]   g_exp;
        logic            wen;
        logic            rsel;
        @(negedge clk);
        rst = 1'b0; wl_in = w; wr_flag = wr; rd_flag = rd; din = d;
        #5;
        wen  = w & wr;
        rsel = w & ~wr;
        for (int i = 0; i < BITS; i++) begin
            g_exp[4*i+0] = ~w & wr;
            g_exp[4*i+1] = wen ? model_q[i] : d[i];
            g_exp[4*i+2] = rsel;
            g_exp[4*i+3] = rsel ? 1'b0 : rd;
        end
        check(wl_out == w, {"R7 wl_out ", tag}, 16'(wl_out), 16'(w));
        check(wr_line == {BITS{wen}}, {"R8 wr_line ", tag}, 16'(wr_line), 16'({BITS{wen}}));
        check(rd_line == {BITS{rsel & rd}}, {"R8 rd_line ", tag}, 16'(rd_line), 16'({BITS{rsel & rd}}));
        check(garbage == g_exp, {"R9 garbage ", tag}, 16'(garbage), 16'(g_exp));
        if (rsel && rd) model_dout = model_q;
        if (wen) model_q = d;
        e.dout = model_dout;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic do_reset(input int n);
        exp_t e;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rst = 1'b1; wl_in = 1'b0; wr_flag = 1'b0; rd_flag = 1'b0;
            #5;
            model_q    = '0;
            model_dout = '0;
            e.dout = '0;
            e.tag  = "R1 reset";
            sb_q.push_back(e);
        end
    endtask

    // Monitor: compare data-out one edge after each driven cycle.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(dout === e.dout, {"dout ", e.tag}, 16'(dout), 16'(e.dout));
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(3);
        op(1, 0, 1, 2'b00, "R1 read after reset");
        op(1, 1, 0, 2'b10, "R3 write 10");
        op(1, 0, 1, 2'b00, "R4 read 10");
        op(0, 1, 0, 2'b01, "R2 wl low write ignored");
        op(0, 1, 1, 2'b11, "R2 wl low both flags");
        op(1, 0, 1, 2'b00, "R2 read still 10");
        op(1, 1, 1, 2'b01, "R5 write wins over read");
        op(1, 0, 1, 2'b00, "R5 read 01");
        op(0, 0, 1, 2'b10, "R6 read flag without wl");
        op(1, 0, 0, 2'b10, "R6 wl only hold");
        op(1, 1, 0, 2'b11, "R3 write 11");
        op(1, 0, 1, 2'b00, "R4 read 11");
        op(1, 1, 0, 2'b00, "R3 write 00");
        op(1, 0, 1, 2'b11, "R4 read 00");
        op(1, 1, 0, 2'b11, "R1 preload ones");
        op(1, 0, 1, 2'b00, "R1 ones read");
        do_reset(1);
        op(1, 0, 1, 2'b00, "R1 read cleared");
        for (int pat = 0; pat < 2; pat++) begin
            op(1, 1, 0, pat ? 2'b01 : 2'b10, "R3 pattern load");
            for (int c = 0; c < 8; c++) begin
                op(c[2], c[1], c[0], pat ? 2'b10 : 2'b01, "R9 control sweep");
            end
            op(1, 0, 1, 2'b00, "R4 sweep readback");
        end
        @(negedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", 16'(sb_q.size()), 16'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule